// File: doc/BRIEF.md
# Disk Sector Start-Offset Generator

This block turns the address fields of a disk command into the byte offset where a transfer starts. A command engine loads the drive/head byte, the two cylinder bytes and the sector number byte, and then pulses `start`. The block takes the drive bit from the drive/head byte and reads that drive's geometry. The geometry is the bytes per sector, the number of heads and the sectors per track. A mode bit in the same byte chooses how the fields are read. In linear mode the fields are packed into a 28-bit block number. In cylinder/head/sector mode the block number is built from the geometry, with sectors counted from one.

One shift-and-add multiplier is used for every product, so the block takes several cycles. It raises `busy` while it works and then gives a one-cycle `done` pulse. At that pulse the offset, the block size, the chosen drive and an error flag are valid, and they stay unchanged until the next command finishes. An error is flagged when cylinder/head/sector mode has a zero head count, a zero sectors-per-track count or a sector number of zero. When no drive takes part in the command, the offset is zero and the block size is 512 bytes.

Top module: `sector_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `err` and `drive_sel` are 0, `start_offset` is 0 and `blk_bytes` is 512.
- R2: A `start` pulse while `busy` is 0 raises `busy` in the next cycle. A `start` seen while `busy` is 1 has no effect: no extra `done` follows and the result in progress is unchanged.
- R3: When bit 6 of `dh_reg` is 1 (linear mode), the block number is {`dh_reg`[3:0], `cyl_hi`, `cyl_lo`, `sec_num`}, with `sec_num` as the least significant byte. `start_offset` is that block number times the sector size.
- R4: Bit 4 of `dh_reg` picks drive 1 when it is 1 and drive 0 when it is 0. The chosen drive's geometry is used, and `drive_sel` reports the choice.
- R5: When bit 6 of `dh_reg` is 0 (cylinder/head/sector mode), `start_offset` = ((C × heads + H) × sectors_per_track + S − 1) × sector size. Here C = {`cyl_hi`,`cyl_lo`}, H = `dh_reg`[3:0] and S = `sec_num`.
- R6: In cylinder/head/sector mode, if the chosen drive has a zero head count or a zero sectors-per-track count, `err` is 1 and `start_offset` is 0.
- R7: In cylinder/head/sector mode, a `sec_num` of 0 sets `err` to 1 and `start_offset` to 0.
- R8: A sector-size input of 0 for a drive means 512 bytes. `blk_bytes` reports the sector size that was used.
- R9: When `no_drive` is 1 at start, the result is `start_offset` 0, `blk_bytes` 512, `drive_sel` 0 and `err` 0, whatever the address fields hold.
- R10: `done` is high for exactly one cycle per accepted start. `done` and `busy` are never high together. All result outputs change only in the `done` cycle.
- R11: The offset is 40 bits wide, so the largest linear block number (0xFFFFFFF) times a 4096-byte sector gives 0xFFFFFFF000 with no loss.
- R12: `done` arrives no more than 3 × (MB_W + 3) + 3 cycles after the accepted start. MB_W is the widest multiplier operand, 13 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to compute an offset |
| no_drive | input | 1 | Command has no drive; result is offset 0, 512-byte block |
| dh_reg | input | 8 | Drive/head byte: [6] linear mode, [4] drive, [3:0] head or top block bits |
| cyl_hi | input | 8 | Cylinder high byte |
| cyl_lo | input | 8 | Cylinder low byte |
| sec_num | input | 8 | Sector number byte |
| geo_bytes | input | 2*SZ_W | Bytes per sector, drive 0 in low slice; 0 means 512 |
| geo_heads | input | 2*HD_W | Head count per drive, drive 0 in low slice |
| geo_spt | input | 2*SPT_W | Sectors per track per drive, drive 0 in low slice |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Address could not be formed (held with result) |
| drive_sel | output | 1 | Drive used for the result |
| start_offset | output | OFS_W | Start byte offset |
| blk_bytes | output | SZ_W | Block size used for the result |

## Verification
The bench aims at the places where a small slip gives a plausible but wrong offset. These are the one-based sector count (a design that forgets the −1 is off by one whole block), the order of the heads and sectors-per-track products (a swap only shows up when the two differ), and the drive bit (using the wrong drive's geometry changes both the size and the product). It also drives the largest linear block with the largest sector size, where a short product register would cut off the upper bits. It checks each error cause on its own: zero heads, zero sectors per track and sector zero. It checks that a sector size of zero falls back to 512 bytes, and that a start given while the block is busy neither disturbs the result nor adds a second `done`.

// File: rtl/sag_pkg.sv
// Shared types for the sector start-offset generator.
// Assumes exactly two drives per interface, selected by one bit.
package sag_pkg;

    localparam int unsigned NUM_DRIVES   = 2;
    localparam int unsigned DEF_SEC_BYTES = 512;
    localparam int unsigned LBA_W        = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MUL_CYL,
        ST_MUL_TRK,
        ST_MUL_SIZE
    } sag_state_t;

    typedef struct packed {
        logic        linear;
        logic        drive;
        logic [3:0]  head;
        logic [15:0] cyl;
        logic [7:0]  sec;
    } taskfile_t;

endpackage

// File: rtl/sag_field_decode.sv
// Splits the address bytes into mode, drive, head, cylinder and sector
// fields, and packs the linear block number.
// Purely combinational; assumes the bytes are steady when sampled.
module sag_field_decode
    import sag_pkg::*;
(
    input  logic [7:0]       dh_reg,
    input  logic [7:0]       cyl_hi,
    input  logic [7:0]       cyl_lo,
    input  logic [7:0]       sec_num,
    output taskfile_t        fields,
    output logic [LBA_W-1:0] lba
);

    // Field extraction from the drive/head byte and the cylinder bytes.
    always_comb begin
        fields.linear = dh_reg[6];
        fields.drive  = dh_reg[4];
        fields.head   = dh_reg[3:0];
        fields.cyl    = {cyl_hi, cyl_lo};
        fields.sec    = sec_num;
    end

    // Linear block number, sector byte least significant.
    always_comb begin
        lba = {dh_reg[3:0], cyl_hi, cyl_lo, sec_num};
    end

endmodule

// File: rtl/sag_geom_sel.sv
// Picks one drive's geometry from the flattened per-drive inputs and
// turns a zero sector size into the 512-byte default.
// Assumes SZ_W is wide enough to hold 512.
module sag_geom_sel
    import sag_pkg::*;
#(
    parameter int SZ_W  = 13,
    parameter int HD_W  = 5,
    parameter int SPT_W = 8
) (
    input  logic [NUM_DRIVES*SZ_W-1:0]  geo_bytes,
    input  logic [NUM_DRIVES*HD_W-1:0]  geo_heads,
    input  logic [NUM_DRIVES*SPT_W-1:0] geo_spt,
    input  logic                        sel,
    output logic [SZ_W-1:0]             size_eff,
    output logic [HD_W-1:0]             heads,
    output logic [SPT_W-1:0]            spt
);

    logic [SZ_W-1:0]  size_fix [NUM_DRIVES];
    logic [HD_W-1:0]  hd_arr   [NUM_DRIVES];
    logic [SPT_W-1:0] spt_arr  [NUM_DRIVES];

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        // Per-drive slice unpacking with the sector-size default applied.
        always_comb begin
            if (geo_bytes[d*SZ_W +: SZ_W] == '0)
                size_fix[d] = SZ_W'(DEF_SEC_BYTES);
            else
                size_fix[d] = geo_bytes[d*SZ_W +: SZ_W];
            hd_arr[d]  = geo_heads[d*HD_W +: HD_W];
            spt_arr[d] = geo_spt[d*SPT_W +: SPT_W];
        end
    end

    // Drive selection.
    always_comb begin
        size_eff = size_fix[sel];
        heads    = hd_arr[sel];
        spt      = spt_arr[sel];
    end

endmodule

// File: rtl/sag_seq_mul.sv
// Radix-2 shift-and-add multiplier: one multiplier bit per cycle.
// A load pulse captures the operands. B_W cycles later the product is
// valid in the cycle where done pulses, and it stays there until the
// next load. The product is truncated to A_W bits; callers size A_W.
module sag_seq_mul #(
    parameter int A_W = 40,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [A_W-1:0] prod,
    output logic           done
);

    localparam int CNT_W = $clog2(B_W + 1);

    logic [A_W-1:0]   a_q;
    logic [B_W-1:0]   b_q;
    logic [CNT_W-1:0] cnt_q;

    // Operand load, then one conditional add and shift per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            prod  <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ld) begin
                a_q   <= a_in;
                b_q   <= b_in;
                prod  <= '0;
                cnt_q <= CNT_W'(B_W);
            end else if (cnt_q != '0) begin
                if (b_q[0])
                    prod <= prod + a_q;
                a_q   <= a_q << 1;
                b_q   <= b_q >> 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sector_addr_gen.sv
// Sector start-offset generator. Captures the address bytes and the
// chosen drive's geometry on start, checks them, and runs up to three
// products on one shared sequential multiplier. Assumes start is a
// one-cycle pulse and that the inputs are steady in the start cycle.
module sector_addr_gen
    import sag_pkg::*;
#(
    parameter int OFS_W = 40,
    parameter int SZ_W  = 13,
    parameter int HD_W  = 5,
    parameter int SPT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        no_drive,
    input  logic [7:0]                  dh_reg,
    input  logic [7:0]                  cyl_hi,
    input  logic [7:0]                  cyl_lo,
    input  logic [7:0]                  sec_num,
    input  logic [NUM_DRIVES*SZ_W-1:0]  geo_bytes,
    input  logic [NUM_DRIVES*HD_W-1:0]  geo_heads,
    input  logic [NUM_DRIVES*SPT_W-1:0] geo_spt,
    output logic                        busy,
    output logic                        done,
    output logic                        err,
    output logic                        drive_sel,
    output logic [OFS_W-1:0]            start_offset,
    output logic [SZ_W-1:0]             blk_bytes
);

    localparam int MB_W = (SZ_W > SPT_W) ? ((SZ_W > HD_W) ? SZ_W : HD_W)
                                         : ((SPT_W > HD_W) ? SPT_W : HD_W);

    taskfile_t        fields, tf_q;
    logic [LBA_W-1:0] lba, lba_q;
    logic [SZ_W-1:0]  size_sel, size_q;
    logic [HD_W-1:0]  heads_sel, heads_q;
    logic [SPT_W-1:0] spt_sel, spt_q;
    logic             nodrv_q;

    sag_state_t       state_q;
    logic             mul_ld_q;
    logic [OFS_W-1:0] mul_a_q;
    logic [MB_W-1:0]  mul_b_q;
    logic [OFS_W-1:0] mul_prod;
    logic             mul_done;

    sag_field_decode u_decode (
        .dh_reg (dh_reg),
        .cyl_hi (cyl_hi),
        .cyl_lo (cyl_lo),
        .sec_num(sec_num),
        .fields (fields),
        .lba    (lba)
    );

    sag_geom_sel #(
        .SZ_W (SZ_W),
        .HD_W (HD_W),
        .SPT_W(SPT_W)
    ) u_geom (
        .geo_bytes(geo_bytes),
        .geo_heads(geo_heads),
        .geo_spt  (geo_spt),
        .sel      (fields.drive),
        .size_eff (size_sel),
        .heads    (heads_sel),
        .spt      (spt_sel)
    );

    sag_seq_mul #(
        .A_W(OFS_W),
        .B_W(MB_W)
    ) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (mul_ld_q),
        .a_in (mul_a_q),
        .b_in (mul_b_q),
        .prod (mul_prod),
        .done (mul_done)
    );

    // Busy whenever the sequencer has left idle.
    always_comb begin
        busy = (state_q != ST_IDLE);
    end

    // Command capture in idle; inputs are not looked at again after this.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_q    <= '0;
            lba_q   <= '0;
            size_q  <= SZ_W'(DEF_SEC_BYTES);
            heads_q <= '0;
            spt_q   <= '0;
            nodrv_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            tf_q    <= fields;
            lba_q   <= lba;
            size_q  <= size_sel;
            heads_q <= heads_sel;
            spt_q   <= spt_sel;
            nodrv_q <= no_drive;
        end
    end

    // Sequencer: check, chain the products, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            mul_ld_q     <= 1'b0;
            mul_a_q      <= '0;
            mul_b_q      <= '0;
            done         <= 1'b0;
            err          <= 1'b0;
            drive_sel    <= 1'b0;
            start_offset <= '0;
            blk_bytes    <= SZ_W'(DEF_SEC_BYTES);
        end else begin
            done     <= 1'b0;
            mul_ld_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start)
                        state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (nodrv_q) begin
                        start_offset <= '0;
                        blk_bytes    <= SZ_W'(DEF_SEC_BYTES);
                        drive_sel    <= 1'b0;
                        err          <= 1'b0;
                        done         <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else if (tf_q.linear) begin
                        mul_a_q  <= OFS_W'(lba_q);
                        mul_b_q  <= MB_W'(size_q);
                        mul_ld_q <= 1'b1;
                        state_q  <= ST_MUL_SIZE;
                    end else if (heads_q == '0 || spt_q == '0 || tf_q.sec == 8'd0) begin
                        start_offset <= '0;
                        blk_bytes    <= size_q;
                        drive_sel    <= tf_q.drive;
                        err          <= 1'b1;
                        done         <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else begin
                        mul_a_q  <= OFS_W'(tf_q.cyl);
                        mul_b_q  <= MB_W'(heads_q);
                        mul_ld_q <= 1'b1;
                        state_q  <= ST_MUL_CYL;
                    end
                end
                ST_MUL_CYL: begin
                    if (mul_done) begin
                        mul_a_q  <= mul_prod + OFS_W'(tf_q.head);
                        mul_b_q  <= MB_W'(spt_q);
                        mul_ld_q <= 1'b1;
                        state_q  <= ST_MUL_TRK;
                    end
                end
                ST_MUL_TRK: begin
                    if (mul_done) begin
                        mul_a_q  <= mul_prod + OFS_W'(tf_q.sec) - OFS_W'(1);
                        mul_b_q  <= MB_W'(size_q);
                        mul_ld_q <= 1'b1;
                        state_q  <= ST_MUL_SIZE;
                    end
                end
                ST_MUL_SIZE: begin
                    if (mul_done) begin
                        start_offset <= mul_prod;
                        blk_bytes    <= size_q;
                        drive_sel    <= tf_q.drive;
                        err          <= 1'b0;
                        done         <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sector_addr_gen_chk.sv
// Protocol checker for the sector start-offset generator, bound to
// every instance of the top module. It watches ports only.
module sector_addr_gen_chk #(
    parameter int OFS_W = 40,
    parameter int SZ_W  = 13,
    parameter int HD_W  = 5,
    parameter int SPT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [OFS_W-1:0] start_offset,
    input logic [SZ_W-1:0]  blk_bytes
);

    localparam int MB_W = (SZ_W > SPT_W) ? ((SZ_W > HD_W) ? SZ_W : HD_W)
                                         : ((SPT_W > HD_W) ? SPT_W : HD_W);
    localparam int LAT_LIM = 3 * (MB_W + 3) + 3;

    logic        past_ok;
    logic [15:0] busy_cnt;

    // Marks cycles whose previous sample was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Counts consecutive busy cycles for the latency bound.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= (busy_cnt == 16'hFFFF) ? busy_cnt : busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_err_zero_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (start_offset == '0));

    assert_blk_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (blk_bytes != '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_offset_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(start_offset)) |-> done);

    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= 16'(LAT_LIM)));

endmodule

bind sector_addr_gen sector_addr_gen_chk #(
    .OFS_W(OFS_W),
    .SZ_W (SZ_W),
    .HD_W (HD_W),
    .SPT_W(SPT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .start_offset(start_offset),
    .blk_bytes   (blk_bytes)
);

// File: tb/sector_addr_gen_tb_top.sv
module sector_addr_gen_tb_top;

    localparam int OFS_W = 40;
    localparam int SZ_W  = 13;
    localparam int HD_W  = 5;
    localparam int SPT_W = 8;
    localparam int LAT_MAX = 3 * (13 + 3) + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic no_drive = 1'b0;
    logic [7:0] dh_reg = '0, cyl_hi = '0, cyl_lo = '0, sec_num = '0;
    logic [2*SZ_W-1:0]  geo_bytes;
    logic [2*HD_W-1:0]  geo_heads;
    logic [2*SPT_W-1:0] geo_spt;
    logic busy, done, err, drive_sel;
    logic [OFS_W-1:0] start_offset;
    logic [SZ_W-1:0]  blk_bytes;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Bench-side geometry, drive 0 and drive 1.
    int g_size[2] = '{0, 4096};
    int g_heads[2] = '{16, 4};
    int g_spt[2] = '{63, 32};

    always #5 clk = ~clk;

    always_comb begin
        geo_bytes = {SZ_W'(g_size[1]), SZ_W'(g_size[0])};
        geo_heads = {HD_W'(g_heads[1]), HD_W'(g_heads[0])};
        geo_spt   = {SPT_W'(g_spt[1]), SPT_W'(g_spt[0])};
    end

    sector_addr_gen #(.OFS_W(OFS_W), .SZ_W(SZ_W), .HD_W(HD_W), .SPT_W(SPT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .no_drive(no_drive),
        .dh_reg(dh_reg), .cyl_hi(cyl_hi), .cyl_lo(cyl_lo), .sec_num(sec_num),
        .geo_bytes(geo_bytes), .geo_heads(geo_heads), .geo_spt(geo_spt),
        .busy(busy), .done(done), .err(err), .drive_sel(drive_sel),
        .start_offset(start_offset), .blk_bytes(blk_bytes)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic model(output longint unsigned off, output bit e,
                         output bit d, output int blk);
        int sz;
        longint unsigned blkno;
        d  = dh_reg[4];
        sz = (g_size[d] == 0) ? 512 : g_size[d];
        blk = sz;
        e = 1'b0;
        off = 0;
        if (no_drive) begin
            d = 1'b0; blk = 512;
        end else if (dh_reg[6]) begin
            blkno = {36'd0, dh_reg[3:0], cyl_hi, cyl_lo, sec_num};
            off = blkno * longint'(sz);
        end else if (g_heads[d] == 0 || g_spt[d] == 0 || sec_num == 0) begin
            e = 1'b1;
        end else begin
            blkno = (longint'({cyl_hi, cyl_lo}) * g_heads[d] + dh_reg[3:0]) * g_spt[d]
                    + sec_num - 1;
            off = blkno * longint'(sz);
        end
    endtask

    // Issue one command, wait for done, compare everything.
    task automatic run_cmd(input string req, input logic nd, input logic [7:0] dh,
                           input logic [7:0] ch, input logic [7:0] cl, input logic [7:0] sn);
        longint unsigned eo; bit ee, ed; int eb; int n = 0;
        @(negedge clk);
        no_drive = nd; dh_reg = dh; cyl_hi = ch; cyl_lo = cl; sec_num = sn;
        model(eo, ee, ed, eb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R2 busy after start"}, 64'(busy), 64'd1);
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R12 latency bound"}, 64'(n <= LAT_MAX), 64'd1);
        chk({req, " offset"}, 64'(start_offset), eo);
        chk({req, " err"}, 64'(err), 64'(ee));
        chk({req, " R4 drive_sel"}, 64'(drive_sel), 64'(ed));
        chk({req, " R8 blk_bytes"}, 64'(blk_bytes), 64'(eb));
        @(negedge clk);
        chk({req, " R10 done single cycle"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        chk("R1 drive_sel", 64'(drive_sel), 64'd0);
        chk("R1 offset", 64'(start_offset), 64'd0);
        chk("R1 blk_bytes", 64'(blk_bytes), 64'd512);
    endtask

    task automatic t_linear();
        run_cmd("R3 linear drive0 (R8 default size)", 0, 8'h45, 8'h12, 8'h34, 8'h56);
        run_cmd("R3 linear drive1", 0, 8'h52, 8'h00, 8'h01, 8'h03);
    endtask

    task automatic t_max_width();
        run_cmd("R11 max block x4096", 0, 8'h5F, 8'hFF, 8'hFF, 8'hFF);
        chk("R11 exact max offset", 64'(start_offset), 64'h0000_00FF_FFFF_F000);
    endtask

    task automatic t_chs();
        run_cmd("R5 chs drive0", 0, 8'h03, 8'h01, 8'h02, 8'h05);
        run_cmd("R5 chs drive1", 0, 8'h12, 8'h03, 8'hE8, 8'h20);
        run_cmd("R5 chs first sector", 0, 8'h00, 8'h00, 8'h00, 8'h01);
    endtask

    task automatic t_chs_errors();
        run_cmd("R7 sector zero", 0, 8'h01, 8'h00, 8'h05, 8'h00);
        g_heads[1] = 0;
        run_cmd("R6 zero heads", 0, 8'h10, 8'h00, 8'h05, 8'h03);
        g_heads[1] = 4; g_spt[1] = 0;
        run_cmd("R6 zero spt", 0, 8'h10, 8'h00, 8'h05, 8'h03);
        g_spt[1] = 32;
        run_cmd("R6 recovery after err", 0, 8'h10, 8'h00, 8'h05, 8'h03);
    endtask

    task automatic t_no_drive();
        run_cmd("R9 no drive", 1, 8'h5F, 8'h77, 8'h66, 8'h00);
    endtask

    task automatic t_busy_start();
        longint unsigned eo; bit ee, ed; int eb; int n = 0; int extra = 0;
        @(negedge clk);
        no_drive = 0; dh_reg = 8'h02; cyl_hi = 8'h00; cyl_lo = 8'h07; sec_num = 8'h09;
        model(eo, ee, ed, eb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        dh_reg = 8'h5A; cyl_lo = 8'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R2 result unaffected by busy start", 64'(start_offset), eo);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R2 no extra done", 64'(extra), 64'd0);
        chk("R10 offset held", 64'(start_offset), eo);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_linear();
        t_max_width();
        t_chs();
        t_chs_errors();
        t_no_drive();
        t_busy_start();
        summary();
        $finish;
    end

endmodule